// File: doc/BRIEF.md
# USB Control Endpoint Transfer Sequencer

This block runs the control pipe of a USB device (endpoint 0) on top of a packet-level endpoint engine. The engine reports events: a receive-ready flag (a setup packet, or a data packet with its byte count), an abort flag raised when the host ends a transfer early, and a flag for a stall handshake that has just gone out. An event with none of these flags marks a finished transmit or a finished status stage. The block answers with one-cycle command pulses: clear receive-ready, transmit-ready with a packet length, data-end, send-stall, clear-abort and clear-stall-flag.

It sorts each request into one of three kinds: no-data, read or write. It hands the 8 setup bytes to the application and waits for a success or failure reply. For reads the reply also carries a response length. The block then splits the response into packets and adds a zero-length packet when the host would otherwise wait for more data. It also holds the device address. A new address from an address-assignment request is written only once that request's status stage has completed.

Top module: `usb_ctrl_seq`

## Requirements
- R1: Setup bytes arrive little-endian on `setup_i`: request type at [7:0], request code at [15:8], value at [31:16], requested length at [63:48]. A zero length gives kind 0 (no-data). Otherwise bit 7 of the request type gives kind 1 (read), and its absence gives kind 2 (write). No-data and read requests raise `req_valid_o` and show the kind on `req_kind_o`. A write request pulses clear-receive-ready straight away and does not consult the application.
- R2: For a no-data request, a success reply pulses clear-receive-ready and data-end in the same cycle, and the next event completes the status stage. A failure reply pulses send-stall alone and the block returns to idle.
- R3: For a read, a success reply pulses clear-receive-ready. The response length is the smaller of `app_len_i` and the requested length. It is sent as full packets of MPS bytes followed by one shorter packet that holds the remainder, if any. Each packet is one transmit-ready pulse with its length on `tx_len_o`. A failure reply pulses send-stall.
- R4: Every read packet except the last waits for a transmit-done event before the next one goes out. The last packet pulses data-end together with transmit-ready, and the next event completes the status stage.
- R5: When the response length is a multiple of MPS (zero included) and is shorter than the requested length, one zero-length packet follows the full packets as the last packet.
- R6: For a write, a data packet is the last one if its count is below MPS or if the running byte total reaches the requested length. A packet that is not the last pulses clear-receive-ready. The last packet hands the request to the application: success pulses clear-receive-ready with data-end, and failure pulses send-stall.
- R7: An event that carries the stall-sent flag pulses only clear-stall-flag. It changes neither the state nor the running byte count.
- R8: An abort flag outside the no-data status stage pulses clear-abort and returns the block to idle. If receive-ready is set in the same event, that setup packet is decoded at once.
- R9: In the no-data status stage an abort flag is cleared but otherwise ignored, and the event still completes the status stage.
- R10: An address-assignment request (request type 0x00, request code 5, new address in value bits [6:0]) that the application accepts leaves `dev_addr_o` unchanged until its status stage completes. A rejected one never changes it.
- R11: After `rst_ni` or `bus_reset_i` the block is idle, no command pulses, `req_valid_o` is low and `dev_addr_o` is 0. A bus reset also discards a pending address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | Synchronous USB bus reset |
| ev_valid_i | input | 1 | Engine event strobe |
| ev_rxrdy_i | input | 1 | Event flag: packet waiting in the receive FIFO |
| ev_setend_i | input | 1 | Event flag: host aborted the transfer |
| ev_stalled_i | input | 1 | Event flag: stall handshake was sent |
| ev_count_i | input | CNT_W | Byte count of the received data packet |
| setup_i | input | 64 | Setup packet bytes |
| req_valid_o | output | 1 | Request waiting for an application reply |
| req_kind_o | output | 2 | Kind of the request (0 no-data, 1 read, 2 write) |
| req_setup_o | output | 64 | Captured setup bytes |
| app_done_i | input | 1 | Application reply strobe |
| app_ok_i | input | 1 | Reply outcome: 1 success, 0 failure |
| app_len_i | input | 16 | Response length for a read |
| cmd_rxrdy_clr_o | output | 1 | Pulse: clear receive-ready |
| cmd_tx_rdy_o | output | 1 | Pulse: transmit-ready |
| cmd_data_end_o | output | 1 | Pulse: data-end |
| cmd_stall_o | output | 1 | Pulse: send stall |
| cmd_setend_clr_o | output | 1 | Pulse: clear abort flag |
| cmd_stalled_clr_o | output | 1 | Pulse: clear stall-sent flag |
| tx_len_o | output | CNT_W | Length of the packet being transmitted |
| dev_addr_o | output | 7 | Device address |

## Verification
The bench sweeps every pairing of response length and requested length up to 20 bytes with an 8-byte packet size. A design that got the split wrong would send the wrong number of packets, drop the zero-length packet or add one, or put data-end on the wrong packet. Writes are swept across lengths with full, short and exact-fit packets. A design that checked only packet size, or only the running total, would end the data stage one packet early or late. Directed cases cover a stall-sent event in the middle of a write, which a faulty design would count toward the total. An abort that carries a fresh setup in the same event, which a faulty design would lose, and an abort that arrives during the no-data status stage, which a faulty design would treat as a real abort and so never write the address. The address is checked before and after its status event and after a bus reset, which catches a write that comes too early or a pending value that survives the reset.

// File: rtl/usb_ctrl_pkg.sv
package usb_ctrl_pkg;
  localparam int DEV_ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_APP, ST_TX, ST_WAIT_TX, ST_RX, ST_WSTAT, ST_ZSTAT
  } st_e;

  typedef enum logic [1:0] {
    K_NODATA = 2'd0,
    K_READ   = 2'd1,
    K_WRITE  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e                 kind;
    logic [15:0]           wlen;
    logic                  set_addr;
    logic [DEV_ADDR_W-1:0] addr;
  } setup_info_t;
endpackage

// File: rtl/usb_ctrl_decode.sv
module usb_ctrl_decode
  import usb_ctrl_pkg::*;
(
  input  logic [63:0]  setup_i,
  output setup_info_t  info_o
);
  logic [7:0]  req_type;
  logic [7:0]  req_code;
  logic [15:0] req_val;
  logic [15:0] req_len;

  assign req_type = setup_i[7:0];
  assign req_code = setup_i[15:8];
  assign req_val  = setup_i[31:16];
  assign req_len  = setup_i[63:48];

  always_comb begin
    info_o.wlen     = req_len;
    info_o.addr     = req_val[DEV_ADDR_W-1:0];
    info_o.set_addr = (req_type == 8'h00) && (req_code == 8'd5) && (req_len == 16'd0);
    if (req_len == 16'd0)  info_o.kind = K_NODATA;
    else if (req_type[7])  info_o.kind = K_READ;
    else                   info_o.kind = K_WRITE;
  end
endmodule

// File: rtl/usb_ctrl_txplan.sv
module usb_ctrl_txplan #(
  parameter int MPS   = 64,
  parameter int CNT_W = $clog2(MPS + 1)
) (
  input  logic [15:0]      resp_i,
  input  logic [15:0]      wlen_i,
  output logic             zlp_o,
  input  logic [15:0]      rem_i,
  input  logic             zlp_i,
  output logic [CNT_W-1:0] len_o,
  output logic             more_o,
  output logic [15:0]      rem_nxt_o
);
  localparam logic [15:0] MPS16 = 16'(MPS);
  localparam bit POW2 = (MPS >= 2) && ((MPS & (MPS - 1)) == 0);

  logic mult;

  generate
    if (POW2) begin : g_mask
      localparam int LG = $clog2(MPS);
      assign mult = (resp_i[LG-1:0] == '0);
    end else begin : g_mod
      assign mult = ((resp_i % MPS16) == 16'd0);
    end
  endgenerate

  assign zlp_o = mult && (resp_i < wlen_i);

  logic full;
  assign full      = (rem_i >= MPS16);
  assign len_o     = full ? CNT_W'(MPS) : rem_i[CNT_W-1:0];
  assign more_o    = (rem_i > MPS16) || ((rem_i == MPS16) && zlp_i);
  assign rem_nxt_o = full ? (rem_i - MPS16) : 16'd0;
endmodule

// File: rtl/usb_ctrl_addr.sv
module usb_ctrl_addr
  import usb_ctrl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_reset_i,
  input  logic                  load_i,
  input  logic [DEV_ADDR_W-1:0] new_i,
  input  logic                  commit_i,
  output logic [DEV_ADDR_W-1:0] addr_o
);
  logic                  pend_q;
  logic [DEV_ADDR_W-1:0] pend_addr_q;
  logic [DEV_ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      addr_q      <= '0;
    end else if (bus_reset_i) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      addr_q      <= '0;
    end else begin
      if (commit_i && pend_q) begin
        addr_q <= pend_addr_q;
        pend_q <= 1'b0;
      end
      if (load_i) begin
        pend_q      <= 1'b1;
        pend_addr_q <= new_i;
      end
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/usb_ctrl_seq.sv
module usb_ctrl_seq
  import usb_ctrl_pkg::*;
#(
  parameter int  MPS   = 64,
  localparam int CNT_W = $clog2(MPS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_reset_i,
  input  logic                  ev_valid_i,
  input  logic                  ev_rxrdy_i,
  input  logic                  ev_setend_i,
  input  logic                  ev_stalled_i,
  input  logic [CNT_W-1:0]      ev_count_i,
  input  logic [63:0]           setup_i,
  output logic                  req_valid_o,
  output logic [1:0]            req_kind_o,
  output logic [63:0]           req_setup_o,
  input  logic                  app_done_i,
  input  logic                  app_ok_i,
  input  logic [15:0]           app_len_i,
  output logic                  cmd_rxrdy_clr_o,
  output logic                  cmd_tx_rdy_o,
  output logic                  cmd_data_end_o,
  output logic                  cmd_stall_o,
  output logic                  cmd_setend_clr_o,
  output logic                  cmd_stalled_clr_o,
  output logic [CNT_W-1:0]      tx_len_o,
  output logic [DEV_ADDR_W-1:0] dev_addr_o
);
  st_e         st_q, st_d;
  setup_info_t info_live, info_q;
  logic [63:0] setup_q;
  logic [15:0] rem_q;
  logic        zlp_q;
  logic [16:0] rx_cnt_q;
  logic [CNT_W-1:0] tx_len_q;

  logic c_rxc, c_txr, c_de, c_stall, c_sec, c_stc;
  logic r_rxc, r_txr, r_de, r_stall, r_sec, r_stc;
  logic do_setup, cap_setup, load_tx, step_tx, rx_acc, rx_clr;
  logic addr_load, addr_commit;

  logic [15:0]      resp;
  logic             zlp_new;
  logic [CNT_W-1:0] plan_len;
  logic             plan_more;
  logic [15:0]      plan_rem;
  logic [16:0]      rx_sum;
  logic             rx_last;

  usb_ctrl_decode u_decode (
    .setup_i (setup_i),
    .info_o  (info_live)
  );

  assign resp = (app_len_i < info_q.wlen) ? app_len_i : info_q.wlen;

  usb_ctrl_txplan #(.MPS(MPS), .CNT_W(CNT_W)) u_txplan (
    .resp_i    (resp),
    .wlen_i    (info_q.wlen),
    .zlp_o     (zlp_new),
    .rem_i     (rem_q),
    .zlp_i     (zlp_q),
    .len_o     (plan_len),
    .more_o    (plan_more),
    .rem_nxt_o (plan_rem)
  );

  usb_ctrl_addr u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .load_i      (addr_load),
    .new_i       (info_q.addr),
    .commit_i    (addr_commit),
    .addr_o      (dev_addr_o)
  );

  assign rx_sum  = rx_cnt_q + 17'(ev_count_i);
  assign rx_last = (ev_count_i < CNT_W'(MPS)) || (rx_sum >= {1'b0, info_q.wlen});

  always_comb begin
    st_d = st_q;
    {c_rxc, c_txr, c_de, c_stall, c_sec, c_stc} = '0;
    {do_setup, cap_setup, load_tx, step_tx, rx_acc, rx_clr} = '0;
    addr_load   = 1'b0;
    addr_commit = 1'b0;

    if (ev_valid_i && ev_stalled_i) begin
      c_stc = 1'b1;
    end else if (ev_valid_i && ev_setend_i && st_q != ST_ZSTAT) begin
      // host abort; a setup in the same event is taken at once
      c_sec    = 1'b1;
      st_d     = ST_IDLE;
      do_setup = ev_rxrdy_i;
    end else begin
      case (st_q)
        ST_IDLE: do_setup = ev_valid_i && ev_rxrdy_i;
        ST_APP: begin
          if (app_done_i) begin
            if (!app_ok_i) begin
              c_stall = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              c_rxc = 1'b1;
              case (info_q.kind)
                K_NODATA: begin
                  c_de      = 1'b1;
                  st_d      = ST_ZSTAT;
                  addr_load = info_q.set_addr;
                end
                K_READ: begin
                  load_tx = 1'b1;
                  st_d    = ST_TX;
                end
                default: begin
                  c_de = 1'b1;
                  st_d = ST_WSTAT;
                end
              endcase
            end
          end
        end
        ST_TX: begin
          c_txr   = 1'b1;
          step_tx = 1'b1;
          if (plan_more) begin
            st_d = ST_WAIT_TX;
          end else begin
            c_de = 1'b1;
            st_d = ST_WSTAT;
          end
        end
        ST_WAIT_TX: if (ev_valid_i) st_d = ST_TX;
        ST_RX: begin
          if (ev_valid_i && ev_rxrdy_i) begin
            rx_acc = 1'b1;
            if (rx_last) st_d = ST_APP;
            else         c_rxc = 1'b1;
          end
        end
        ST_WSTAT: if (ev_valid_i) st_d = ST_IDLE;
        ST_ZSTAT: begin
          if (ev_valid_i) begin
            c_sec       = ev_setend_i;
            st_d        = ST_IDLE;
            addr_commit = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end

    if (do_setup) begin
      cap_setup = 1'b1;
      if (info_live.kind == K_WRITE) begin
        c_rxc  = 1'b1;
        rx_clr = 1'b1;
        st_d   = ST_RX;
      end else begin
        st_d = ST_APP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      info_q   <= '0;
      setup_q  <= '0;
      rem_q    <= '0;
      zlp_q    <= 1'b0;
      rx_cnt_q <= '0;
      tx_len_q <= '0;
      {r_rxc, r_txr, r_de, r_stall, r_sec, r_stc} <= '0;
    end else if (bus_reset_i) begin
      st_q <= ST_IDLE;
      {r_rxc, r_txr, r_de, r_stall, r_sec, r_stc} <= '0;
    end else begin
      st_q <= st_d;
      {r_rxc, r_txr, r_de, r_stall, r_sec, r_stc} <= {c_rxc, c_txr, c_de, c_stall, c_sec, c_stc};
      if (cap_setup) begin
        setup_q <= setup_i;
        info_q  <= info_live;
      end
      if (load_tx) begin
        rem_q <= resp;
        zlp_q <= zlp_new;
      end
      if (step_tx) begin
        rem_q    <= plan_rem;
        tx_len_q <= plan_len;
      end
      if (rx_clr)      rx_cnt_q <= '0;
      else if (rx_acc) rx_cnt_q <= rx_sum;
    end
  end

  assign req_valid_o       = (st_q == ST_APP);
  assign req_kind_o        = info_q.kind;
  assign req_setup_o       = setup_q;
  assign cmd_rxrdy_clr_o   = r_rxc;
  assign cmd_tx_rdy_o      = r_txr;
  assign cmd_data_end_o    = r_de;
  assign cmd_stall_o       = r_stall;
  assign cmd_setend_clr_o  = r_sec;
  assign cmd_stalled_clr_o = r_stc;
  assign tx_len_o          = tx_len_q;
endmodule

// File: rtl/usb_ctrl_seq_chk.sv
module usb_ctrl_seq_chk
  import usb_ctrl_pkg::*;
#(
  parameter int MPS   = 64,
  parameter int CNT_W = $clog2(MPS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_reset_i,
  input logic                  ev_valid_i,
  input logic                  ev_setend_i,
  input logic                  ev_stalled_i,
  input logic                  cmd_rxrdy_clr_o,
  input logic                  cmd_tx_rdy_o,
  input logic                  cmd_data_end_o,
  input logic                  cmd_stall_o,
  input logic                  cmd_setend_clr_o,
  input logic                  cmd_stalled_clr_o,
  input logic [CNT_W-1:0]      tx_len_o,
  input logic [DEV_ADDR_W-1:0] dev_addr_o,
  input st_e                   st_q
);
  assert_stall_flag_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_stalled_i && !bus_reset_i |=>
      cmd_stalled_clr_o && !cmd_rxrdy_clr_o && !cmd_tx_rdy_o && !cmd_stall_o && $stable(st_q));

  assert_data_end_paired_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_data_end_o |-> (cmd_rxrdy_clr_o || cmd_tx_rdy_o));

  assert_stall_alone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stall_o |-> !cmd_rxrdy_clr_o && !cmd_data_end_o && !cmd_tx_rdy_o);

  assert_tx_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tx_rdy_o |-> (tx_len_o <= CNT_W'(MPS)));

  assert_addr_deferred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_reset_i && !(st_q == ST_ZSTAT && ev_valid_i && !ev_stalled_i) |=> $stable(dev_addr_o));

  assert_abort_to_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_setend_i && !ev_stalled_i && !bus_reset_i &&
    st_q != ST_ZSTAT && st_q != ST_IDLE |=>
      cmd_setend_clr_o && (st_q == ST_IDLE || st_q == ST_APP || st_q == ST_RX));
endmodule

bind usb_ctrl_seq usb_ctrl_seq_chk #(.MPS(MPS), .CNT_W(CNT_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .bus_reset_i       (bus_reset_i),
  .ev_valid_i        (ev_valid_i),
  .ev_setend_i       (ev_setend_i),
  .ev_stalled_i      (ev_stalled_i),
  .cmd_rxrdy_clr_o   (cmd_rxrdy_clr_o),
  .cmd_tx_rdy_o      (cmd_tx_rdy_o),
  .cmd_data_end_o    (cmd_data_end_o),
  .cmd_stall_o       (cmd_stall_o),
  .cmd_setend_clr_o  (cmd_setend_clr_o),
  .cmd_stalled_clr_o (cmd_stalled_clr_o),
  .tx_len_o          (tx_len_o),
  .dev_addr_o        (dev_addr_o),
  .st_q              (st_q)
);

// File: tb/usb_ctrl_seq_bench.sv
`timescale 1ns/1ps
module usb_ctrl_seq_bench;
  localparam int M  = 8;
  localparam int CW = $clog2(M + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic ev_valid = 1'b0, ev_rxrdy = 1'b0, ev_setend = 1'b0, ev_stalled = 1'b0;
  logic [CW-1:0] ev_count = '0;
  logic [63:0] setup = '0;
  logic app_done = 1'b0, app_ok = 1'b0;
  logic [15:0] app_len = '0;

  logic          req_valid;
  logic [1:0]    req_kind;
  logic [63:0]   req_setup;
  logic          rxc, txr, de, stall, sec, stc;
  logic [CW-1:0] tx_len;
  logic [6:0]    dev_addr;

  always #2.5 clk = ~clk;

  usb_ctrl_seq #(.MPS(M)) u_usb_ctrl_seq (
    .clk_i (clk), .rst_ni (rst_n), .bus_reset_i (bus_reset),
    .ev_valid_i (ev_valid), .ev_rxrdy_i (ev_rxrdy), .ev_setend_i (ev_setend),
    .ev_stalled_i (ev_stalled), .ev_count_i (ev_count), .setup_i (setup),
    .req_valid_o (req_valid), .req_kind_o (req_kind), .req_setup_o (req_setup),
    .app_done_i (app_done), .app_ok_i (app_ok), .app_len_i (app_len),
    .cmd_rxrdy_clr_o (rxc), .cmd_tx_rdy_o (txr), .cmd_data_end_o (de),
    .cmd_stall_o (stall), .cmd_setend_clr_o (sec), .cmd_stalled_clr_o (stc),
    .tx_len_o (tx_len), .dev_addr_o (dev_addr)
  );

  int n_chk = 0, n_fail = 0;
  int n_rxc = 0, n_txr = 0, n_de = 0, n_stall = 0, n_sec = 0, n_stc = 0;
  int tx_len_log [64];
  bit tx_de_log  [64];
  bit done_flag = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rxc)   n_rxc++;
      if (de)    n_de++;
      if (stall) n_stall++;
      if (sec)   n_sec++;
      if (stc)   n_stc++;
      if (txr) begin
        tx_len_log[n_txr % 64] = int'(tx_len);
        tx_de_log[n_txr % 64]  = de;
        n_txr++;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_ev(bit rx, bit se, bit st, int cnt);
    @(negedge clk);
    ev_valid = 1'b1; ev_rxrdy = rx; ev_setend = se; ev_stalled = st;
    ev_count = cnt[CW-1:0];
    @(negedge clk);
    ev_valid = 1'b0; ev_rxrdy = 1'b0; ev_setend = 1'b0; ev_stalled = 1'b0;
    ev_count = '0;
  endtask

  function automatic logic [63:0] mk_setup(int bm, int br, int val, int wl);
    return {wl[15:0], 16'h0000, val[15:0], br[7:0], bm[7:0]};
  endfunction

  task automatic wait_req();
    for (int i = 0; i < 20 && !req_valid; i++) @(negedge clk);
  endtask

  task automatic reply(bit ok, int len);
    @(negedge clk);
    app_done = 1'b1; app_ok = ok; app_len = len[15:0];
    @(negedge clk);
    app_done = 1'b0;
  endtask

  task automatic do_read(int wl, int al);
    int b_tx, b_rxc, resp, exp_n, got, bad_len, bad_de, exp_len;
    string tag;
    b_tx = n_txr; b_rxc = n_rxc;
    setup = mk_setup(8'h80, 8'h06, 16'h0100, wl);
    send_ev(1, 0, 0, 0);
    wait_req();
    chk("R1", "read kind", int'(req_kind), 1);
    reply(1, al);
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 20 && n_txr <= b_tx + k; i++) @(negedge clk);
      if (n_txr <= b_tx + k) break;
      if (tx_de_log[(b_tx + k) % 64]) break;
      send_ev(0, 0, 0, 0);
    end
    send_ev(0, 0, 0, 0);
    idle(2);
    resp  = (al < wl) ? al : wl;
    exp_n = resp / M + (((resp % M) != 0 || resp < wl) ? 1 : 0);
    got   = n_txr - b_tx;
    bad_len = 0; bad_de = 0;
    for (int k = 0; k < got && k < 8; k++) begin
      exp_len = (k < resp / M) ? M : resp % M;
      if (tx_len_log[(b_tx + k) % 64] != exp_len) bad_len++;
      if (tx_de_log[(b_tx + k) % 64] != (k == got - 1)) bad_de++;
    end
    tag = ((resp % M) == 0 && resp < wl) ? "R5" : "R3";
    chk(tag, $sformatf("packet count wl=%0d len=%0d", wl, al), got, exp_n);
    chk("R3", $sformatf("packet length errors wl=%0d len=%0d", wl, al), bad_len, 0);
    chk("R4", $sformatf("data-end placement errors wl=%0d len=%0d", wl, al), bad_de, 0);
    chk("R3", "receive clear on accept", n_rxc - b_rxc, 1);
    chk("R4", "idle after status", int'(req_valid), 0);
  endtask

  task automatic do_write(int wl, bit short_first, bit ok);
    int b_rxc, b_de, b_stall, br, sent, p;
    bit first, last;
    b_rxc = n_rxc;
    setup = mk_setup(8'h21, 8'h09, 0, wl);
    send_ev(1, 0, 0, 0);
    idle(2);
    chk("R1", "write setup cleared without app", n_rxc - b_rxc, 1);
    chk("R1", "write not offered to app", int'(req_valid), 0);
    sent = 0; first = 1'b1; last = 1'b0;
    while (!last) begin
      p = (short_first && first) ? 3 : M;
      if (p > wl - sent) p = wl - sent;
      last = (p < M) || (sent + p >= wl);
      br = n_rxc;
      send_ev(1, 0, 0, p);
      idle(2);
      sent += p; first = 1'b0;
      if (!last) chk("R6", $sformatf("mid packet clear wl=%0d", wl), n_rxc - br, 1);
      else begin
        chk("R6", $sformatf("last packet to app wl=%0d", wl), int'(req_valid), 1);
        chk("R6", "last packet not cleared early", n_rxc - br, 0);
      end
    end
    b_rxc = n_rxc; b_de = n_de; b_stall = n_stall;
    reply(ok, 0);
    idle(2);
    if (ok) begin
      chk("R6", "write accept clear", n_rxc - b_rxc, 1);
      chk("R6", "write accept data-end", n_de - b_de, 1);
      send_ev(0, 0, 0, 0);
      idle(2);
    end else begin
      chk("R6", "write reject stall", n_stall - b_stall, 1);
      chk("R6", "write reject no data-end", n_de - b_de, 0);
    end
    chk("R6", "idle after write", int'(req_valid), 0);
  endtask

  initial begin
    #(150000 * 5);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b1, b2, b3;
    idle(3);
    chk("R11", "reset address", int'(dev_addr), 0);
    chk("R11", "reset req_valid", int'(req_valid), 0);
    chk("R11", "reset commands", int'({rxc, txr, de, stall, sec, stc}), 0);
    rst_n = 1'b1;
    idle(2);

    // address assignment, accepted, with abort flag during status
    setup = mk_setup(8'h00, 8'h05, 16'h002A, 0);
    send_ev(1, 0, 0, 0);
    wait_req();
    chk("R1", "no-data kind", int'(req_kind), 0);
    chk("R1", "setup captured", int'(req_setup[31:16]), 16'h002A);
    b1 = n_rxc; b2 = n_de;
    reply(1, 0);
    idle(3);
    chk("R2", "no-data accept clear", n_rxc - b1, 1);
    chk("R2", "no-data accept data-end", n_de - b2, 1);
    chk("R10", "address held before status", int'(dev_addr), 0);
    b1 = n_sec;
    send_ev(0, 1, 0, 0);
    idle(2);
    chk("R9", "abort flag cleared in status", n_sec - b1, 1);
    chk("R9", "status completed despite abort flag", int'(dev_addr), 8'h2A);
    chk("R10", "address written after status", int'(dev_addr), 8'h2A);

    // rejected address assignment
    b1 = n_stall; b2 = n_rxc;
    setup = mk_setup(8'h00, 8'h05, 16'h0011, 0);
    send_ev(1, 0, 0, 0);
    wait_req();
    reply(0, 0);
    idle(2);
    chk("R2", "no-data reject stall", n_stall - b1, 1);
    chk("R2", "no-data reject no clear", n_rxc - b2, 0);
    send_ev(0, 0, 0, 0);
    idle(2);
    chk("R10", "rejected address ignored", int'(dev_addr), 8'h2A);

    // control read reject
    b1 = n_stall;
    setup = mk_setup(8'h80, 8'h06, 0, 10);
    send_ev(1, 0, 0, 0);
    wait_req();
    reply(0, 4);
    idle(2);
    chk("R3", "read reject stall", n_stall - b1, 1);

    // read sweep
    for (int wl = 1; wl <= 20; wl++)
      for (int al = 0; al <= 20; al++)
        do_read(wl, al);

    // write sweep
    for (int wl = 1; wl <= 20; wl++) begin
      do_write(wl, 1'b0, wl[0]);
      do_write(wl, 1'b1, 1'b1);
    end

    // stall-sent event in the middle of a write
    setup = mk_setup(8'h21, 8'h09, 0, 20);
    send_ev(1, 0, 0, 0);
    send_ev(1, 0, 0, 8);
    idle(2);
    b1 = n_stc; b2 = n_rxc;
    send_ev(1, 0, 1, 8);
    idle(2);
    chk("R7", "stall flag cleared", n_stc - b1, 1);
    chk("R7", "no clear on stall-flag event", n_rxc - b2, 0);
    b2 = n_rxc;
    send_ev(1, 0, 0, 8);
    idle(2);
    chk("R7", "total not advanced by stall event", n_rxc - b2, 1);
    chk("R7", "still receiving", int'(req_valid), 0);

    // abort carrying a new setup in the same event
    b1 = n_sec; b2 = n_rxc;
    setup = mk_setup(8'h00, 8'h09, 1, 0);
    send_ev(1, 1, 0, 0);
    idle(2);
    chk("R8", "abort flag cleared", n_sec - b1, 1);
    chk("R8", "pending setup decoded", int'(req_valid), 1);
    chk("R8", "new request kind", int'(req_kind), 0);
    reply(1, 0);
    send_ev(0, 0, 0, 0);
    idle(2);

    // abort while waiting for transmit done
    b1 = n_sec; b3 = n_txr;
    setup = mk_setup(8'h80, 8'h06, 0, 20);
    send_ev(1, 0, 0, 0);
    wait_req();
    reply(1, 20);
    idle(3);
    send_ev(0, 1, 0, 0);
    idle(3);
    chk("R8", "abort during data stage", n_sec - b1, 1);
    chk("R8", "no further packets after abort", n_txr - b3, 1);
    chk("R8", "idle after abort", int'(req_valid), 0);

    // bus reset in the middle of a write
    setup = mk_setup(8'h21, 8'h09, 0, 20);
    send_ev(1, 0, 0, 0);
    idle(1);
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    idle(1);
    chk("R11", "bus reset clears address", int'(dev_addr), 0);
    chk("R11", "bus reset idle", int'(req_valid), 0);
    setup = mk_setup(8'h00, 8'h01, 0, 0);
    send_ev(1, 0, 0, 0);
    idle(2);
    chk("R11", "setup taken after bus reset", int'(req_valid), 1);
    reply(1, 0);
    send_ev(0, 0, 0, 0);
    idle(2);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule